// File: doc/BRIEF.md
# Level and Pin-Change Interrupt Controller

This block gathers interrupt requests for a small processor core and hands them over one at a time. One source is an active-low, level-sensitive request line. Its pending state follows the synchronised pin directly and is never latched. The other sources are three groups of pin-change inputs. Each group has a per-pin mask and exactly one sticky pending flag. That flag is set by any change, in either direction, on an unmasked pin of the group.

A global enable bit gates delivery to the core. The core sees a request line and a vector index. It answers with an entry strobe when it starts a handler and a return strobe when the handler finishes. Entry clears the global enable, so handlers never nest, and return sets it again. A request that arrives while delivery is disabled stays pending. It is offered to the core in the cycle after the enable is set again.

Software reaches the enable bit, the flags and the masks through a small register port. A write of 1 clears a flag bit. A separate strobe input lets software force a group's flag.

Top module: `lpi_ctrl`

## Requirements
- R1: The external line `ext_req_n` is active low and passes through two synchronising flops. While it is held low and global enable is 1, `irq_req` is high with `irq_vec` = 0, and this holds across handler entry and return. It has no flag: servicing it leaves the group flags unchanged, and writing ones to the flag register does not remove it.
- R2: A request pending while global enable is 0 is not lost. It appears on `irq_req` in the cycle after a register write that sets global enable.
- R3: An entry strobe (`irq_ack` high while `irq_req` is high) clears global enable. `irq_req` is low in the following cycle.
- R4: A return strobe `irq_ret` sets global enable to 1.
- R5: A change on an unmasked pin of group g sets flag g, even while global enable is 0. The flag is visible three clock edges after the pin changes: two synchroniser stages plus the flag register.
- R6: Changes on masked pins (mask bit 0) never set a flag.
- R7: Any number of rising and falling changes in a group leave the single flag set to 1. One service clears it, and no second request follows.
- R8: The three groups are independent. Group g is delivered with `irq_vec` = g+1.
- R9: A pulse on `flag_set[g]` sets flag g.
- R10: An entry strobe for vector g+1 clears flag g only. Where a set event coincides with a clear, the set wins.
- R11: Writing to the flag register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R12: The fixed priority is the external line first, then groups 0, 1 and 2.
- R13: The register map is as follows. Address 0 bit 0 is global enable. Address 1 bits [2:0] are the flags of groups 0 to 2. Addresses 2, 3 and 4 are the masks of groups 0, 1 and 2. `reg_rdata` reflects `reg_addr` combinationally. After reset, enable, flags and masks are all 0 and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | Active-low level request line |
| pc_pins | input | GROUPS*PINS | Pin-change inputs, group g at bits [g*PINS +: PINS] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | PINS | Register write data |
| reg_rdata | output | PINS | Register read data |
| flag_set | input | GROUPS | Software set strobe, one bit per group |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Index of the winning source |
| irq_ack | input | 1 | Handler entry strobe |
| irq_ret | input | 1 | Handler return strobe |

## Verification
The checker takes four things for granted about the core. `irq_ack` is raised only while `irq_req` is high. `irq_ack` and `irq_ret` never share a cycle. A register write to the enable bit never coincides with either strobe. Pins hold a steady value through reset. The bench drives each strobe for exactly one cycle, and only after it has seen a live request. It holds all pins low during reset. It waits for pin activity to settle before it issues an entry, so that no fresh change races the clearing of a flag.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
   localparam int unsigned REG_CTRL      = 0;
   localparam int unsigned REG_FLAGS     = 1;
   localparam int unsigned REG_MASK_BASE = 2;
   localparam int unsigned EXT_VEC       = 0;
endpackage

// File: rtl/lpi_sync.sv
module lpi_sync #(
   parameter int unsigned W       = 1,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= RST_VAL;
            s2 <= RST_VAL;
         end else begin
            s1 <= d[i];
            s2 <= s1;
         end
      end
      assign q[i] = s2;
   end
endmodule

// File: rtl/lpi_pcgroup.sv
module lpi_pcgroup #(
   parameter int unsigned PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pins_s,
   input  logic [PINS-1:0] mask,
   output logic            hit
);
   logic [PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins_s;
   end

   assign hit = |((pins_s ^ prev_q) & mask);
endmodule

// File: rtl/lpi_arbiter.sv
module lpi_arbiter #(
   parameter int unsigned N     = 4,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/lpi_ctrl.sv
module lpi_ctrl #(
   parameter int unsigned GROUPS = 3,
   parameter int unsigned PINS   = 8,
   localparam int unsigned NSRC   = GROUPS + 1,
   localparam int unsigned VEC_W  = $clog2(NSRC),
   localparam int unsigned ADDR_W = $clog2(GROUPS + 2)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ext_req_n,
   input  logic [GROUPS*PINS-1:0] pc_pins,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [PINS-1:0]        reg_wdata,
   output logic [PINS-1:0]        reg_rdata,
   input  logic [GROUPS-1:0]      flag_set,
   output logic                   irq_req,
   output logic [VEC_W-1:0]       irq_vec,
   input  logic                   irq_ack,
   input  logic                   irq_ret
);
   import lpi_pkg::*;

   if (PINS < GROUPS) begin : g_bad_width
      $error("lpi_ctrl: PINS must be at least GROUPS");
   end
   if (GROUPS < 1) begin : g_bad_groups
      $error("lpi_ctrl: GROUPS must be at least 1");
   end

   logic                   ext_s;
   logic                   ext_pend;
   logic [GROUPS*PINS-1:0] pins_s;
   logic [GROUPS-1:0]      grp_hit;
   logic [GROUPS-1:0]      flag_q;
   logic [PINS-1:0]        mask_q [GROUPS];
   logic                   gie_q;
   logic [NSRC-1:0]        src_req;
   logic                   src_any;
   logic                   ack_fire;
   logic                   wr_ctrl, wr_flags;

   lpi_sync #(.W(1), .RST_VAL(1'b1)) ext_sync_i (
      .clk(clk), .rst_n(rst_n), .d(ext_req_n), .q(ext_s));
   assign ext_pend = ~ext_s;

   lpi_sync #(.W(GROUPS*PINS), .RST_VAL(1'b0)) pin_sync_i (
      .clk(clk), .rst_n(rst_n), .d(pc_pins), .q(pins_s));

   assign wr_ctrl  = reg_we && (reg_addr == ADDR_W'(REG_CTRL));
   assign wr_flags = reg_we && (reg_addr == ADDR_W'(REG_FLAGS));
   assign ack_fire = irq_ack && irq_req;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic wr_mask;
      logic svc;

      lpi_pcgroup #(.PINS(PINS)) det_i (
         .clk(clk), .rst_n(rst_n),
         .pins_s(pins_s[g*PINS +: PINS]),
         .mask(mask_q[g]),
         .hit(grp_hit[g]));

      assign wr_mask = reg_we && (reg_addr == ADDR_W'(REG_MASK_BASE + g));
      assign svc     = ack_fire && (irq_vec == VEC_W'(g + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mask_q[g] <= '0;
         else if (wr_mask) mask_q[g] <= reg_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          flag_q[g] <= 1'b0;
         else if (grp_hit[g] || flag_set[g])  flag_q[g] <= 1'b1;
         else if (svc || (wr_flags && reg_wdata[g])) flag_q[g] <= 1'b0;
      end

      assign src_req[g+1] = flag_q[g];
   end

   assign src_req[EXT_VEC] = ext_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gie_q <= 1'b0;
      else if (ack_fire) gie_q <= 1'b0;
      else if (irq_ret)  gie_q <= 1'b1;
      else if (wr_ctrl)  gie_q <= reg_wdata[0];
   end

   lpi_arbiter #(.N(NSRC)) arb_i (
      .req(src_req), .any(src_any), .idx(irq_vec));

   assign irq_req = gie_q && src_any;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(REG_CTRL)) begin
         reg_rdata[0] = gie_q;
      end else if (reg_addr == ADDR_W'(REG_FLAGS)) begin
         reg_rdata[GROUPS-1:0] = flag_q;
      end else begin
         for (int g = 0; g < GROUPS; g++) begin
            if (reg_addr == ADDR_W'(REG_MASK_BASE + g)) reg_rdata = mask_q[g];
         end
      end
   end
endmodule

// File: rtl/lpi_ctrl_chk.sv
module lpi_ctrl_chk #(
   parameter int unsigned GROUPS = 3,
   parameter int unsigned VEC_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic [VEC_W-1:0]  irq_vec,
   input logic              irq_ack,
   input logic              irq_ret,
   input logic              gie,
   input logic              ext_pend,
   input logic [GROUPS-1:0] flags,
   input logic [GROUPS-1:0] grp_hit,
   input logic [GROUPS-1:0] flag_set
);
   a_r2_gated_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq_req);

   a_r3_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !irq_req);

   a_r4_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_ack) |=> gie);

   a_r5_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (|grp_hit) |=> ((flags & $past(grp_hit)) == $past(grp_hit)));

   a_r9_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_set) |=> ((flags & $past(flag_set)) == $past(flag_set)));

   a_r12_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && ext_pend) |-> (irq_vec == '0));

   a_r8_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (int'(irq_vec) <= GROUPS));
endmodule

bind lpi_ctrl lpi_ctrl_chk #(.GROUPS(GROUPS), .VEC_W(VEC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
   .irq_ack(irq_ack), .irq_ret(irq_ret), .gie(gie_q), .ext_pend(ext_pend),
   .flags(flag_q), .grp_hit(grp_hit), .flag_set(flag_set));

// File: tb/lpi_ctrl_tb.sv
`timescale 1ns/1ps
module lpi_ctrl_tb_top;
   localparam int GROUPS = 3;
   localparam int PINS   = 8;
   localparam int AW     = 3;
   localparam int VW     = 2;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   ext_req_n;
   logic [GROUPS*PINS-1:0] pc_pins;
   logic                   reg_we;
   logic [AW-1:0]          reg_addr;
   logic [PINS-1:0]        reg_wdata;
   logic [PINS-1:0]        reg_rdata;
   logic [GROUPS-1:0]      flag_set;
   logic                   irq_req;
   logic [VW-1:0]          irq_vec;
   logic                   irq_ack;
   logic                   irq_ret;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   string q_rq[$];
   int    q_kind[$];
   int    q_a[$];
   int    q_b[$];

   always #4 clk = ~clk;

   lpi_ctrl #(.GROUPS(GROUPS), .PINS(PINS)) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .pc_pins(pc_pins),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .flag_set(flag_set), .irq_req(irq_req),
      .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret));

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         wait (q_rq.size() != 0);
         #1;
         while (q_rq.size() != 0) begin
            string rq;
            int k, a, b;
            rq = q_rq.pop_front();
            k  = q_kind.pop_front();
            a  = q_a.pop_front();
            b  = q_b.pop_front();
            n_tests++;
            if (k == 0) begin
               if (int'(irq_req) != a || (a == 1 && int'(irq_vec) != b)) begin
                  n_fail++;
                  $display("FAIL %s: req/vec actual %0d/%0d expected %0d/%0d",
                           rq, irq_req, irq_vec, a, b);
               end
            end else begin
               if (int'(reg_rdata) != b) begin
                  n_fail++;
                  $display("FAIL %s: reg[%0d] actual 0x%0h expected 0x%0h",
                           rq, a, reg_rdata, b);
               end
            end
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic exp_irq(string rq, int req, int vec);
      q_rq.push_back(rq); q_kind.push_back(0); q_a.push_back(req); q_b.push_back(vec);
      wait (q_rq.size() == 0);
   endtask

   task automatic exp_reg(string rq, int addr, int data);
      reg_addr = AW'(addr);
      q_rq.push_back(rq); q_kind.push_back(1); q_a.push_back(addr); q_b.push_back(data);
      wait (q_rq.size() == 0);
   endtask

   task automatic wr(int addr, int data);
      reg_we = 1'b1; reg_addr = AW'(addr); reg_wdata = PINS'(data);
      tick(1);
      reg_we = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
   endtask

   task automatic ret();
      irq_ret = 1'b1; tick(1); irq_ret = 1'b0;
   endtask

   task automatic toggle(int bit_i);
      pc_pins[bit_i] = ~pc_pins[bit_i];
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ext_req_n = 1'b1; pc_pins = '0; reg_we = 1'b0;
      reg_addr = '0; reg_wdata = '0; flag_set = '0; irq_ack = 1'b0; irq_ret = 1'b0;
      tick(4);
      rst_n = 1'b1;
      tick(1);

      // R13 reset state and register map
      exp_irq("R13", 0, 0);
      exp_reg("R13", 0, 0);
      exp_reg("R13", 1, 0);
      wr(2, 8'hA5); exp_reg("R13", 2, 8'hA5);
      wr(3, 8'h3C); exp_reg("R13", 3, 8'h3C);
      wr(3, 0);
      wr(2, 8'h01); exp_reg("R13", 2, 8'h01);

      // R6 masked pin ignored
      toggle(1); tick(4); exp_reg("R6", 1, 0);

      // R5 unmasked change sets flag while enable is off
      toggle(0); tick(2); exp_reg("R5", 1, 0);
      tick(1); exp_reg("R5", 1, 1); exp_irq("R5", 0, 0);

      // R7 several rise/fall changes keep one flag
      toggle(0); tick(1); toggle(0); tick(1); toggle(0); tick(4);
      exp_reg("R7", 1, 1);

      // R2 delivered right after enable
      wr(0, 1); exp_irq("R2", 1, 1);

      // R3 entry, R10 flag cleared
      ack(); exp_irq("R3", 0, 0); exp_reg("R10", 1, 0); exp_reg("R3", 0, 0);
      ret(); exp_reg("R4", 0, 1); exp_irq("R7", 0, 0);

      // R9 software set, R11 write-one-to-clear
      wr(0, 0);
      flag_set = 3'b010; tick(1); flag_set = '0;
      exp_reg("R9", 1, 2);
      wr(1, 0); exp_reg("R11", 1, 2);
      wr(1, 5); exp_reg("R11", 1, 2);
      wr(1, 2); exp_reg("R11", 1, 0);

      // R12 priority, R1 level line, R8 vectors
      flag_set = 3'b111; tick(1); flag_set = '0;
      ext_req_n = 1'b0; tick(2);
      exp_irq("R1", 0, 0);
      wr(0, 1); exp_irq("R12", 1, 0);
      ack(); exp_irq("R3", 0, 0); exp_reg("R1", 1, 7);
      ret(); exp_irq("R1", 1, 0);
      ext_req_n = 1'b1; tick(2); exp_irq("R12", 1, 1);
      ack(); exp_reg("R10", 1, 6); exp_irq("R3", 0, 0);
      ret(); exp_irq("R8", 1, 2);
      ack(); exp_reg("R10", 1, 4);
      ret(); exp_irq("R8", 1, 3);
      ack(); exp_reg("R10", 1, 0);
      ret(); exp_irq("R8", 0, 0);

      // R1 software cannot clear the level request
      ext_req_n = 1'b0; tick(2); exp_irq("R1", 1, 0);
      wr(1, 8'hFF); exp_irq("R1", 1, 0);
      ext_req_n = 1'b1; tick(2); exp_irq("R1", 0, 0);

      tick(2);
      done = 1;
      summary();
      $finish;
   end
endmodule